// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host-side master for a sampling ADC on a four-wire serial link. On a request it opens a frame by pulling the chip select low and runs sixteen serial clock periods. In the first eight periods it shifts out a control word that carries the power-mode bits and a configuration field. It collects sixteen result bits from the converter on the serial data input and returns them as one word with a one-cycle valid strobe. A busy flag covers the whole exchange.

The power-mode bits are sent again in every frame. The sequencer also adds the converter's power-up delay where the chosen mode needs it. In auto power-down mode the delay is placed inside the frame, between the first falling and the second rising serial clock edge. In chip-select-controlled power-down mode the delay goes between the chip select falling edge and the first clock edge. A host whose frame timing is fixed cannot stretch that gap, so it can ask for a wake-up pair instead. The first frame is a throwaway conversion that writes the always-on code to wake the converter. The second frame writes the requested code and gives the only result that is reported.

Serial clock half-periods, the power-up delay and the frame layout are parameters in system clock cycles.

Top module: `adc_conv_seq`

## Requirements
- R1: While reset is active, and whenever no request is in progress, `adc_cs_n` and `adc_sclk` are high, `busy` and `result_valid` are low, and `adc_din` is low.
- R2: During a frame `adc_cs_n` stays low for exactly FRAME_BITS rising edges of `adc_sclk`, and `adc_sclk` toggles only while `adc_cs_n` is low. Between frames `adc_cs_n` stays high for at least 2*CLK_DIV system cycles.
- R3: On the first CTRL_BITS rising `adc_sclk` edges of a frame, `adc_din` carries the control word MSB first. The word is {mode[1:0], cfg}, with mode in the two top bits. `adc_din` changes only at falling `adc_sclk` edges and is low after the control word.
- R4: `adc_dout` is sampled at each rising `adc_sclk` edge. `result` holds the FRAME_BITS samples with the first sample as the MSB.
- R5: `busy` rises in the cycle after `start` is accepted. It falls in the same cycle as a one-cycle `result_valid` pulse. A `start` while `busy` is high is ignored, and so are changes to `pm_sel`, `cfg` and `wake_dummy` during that time.
- R6: Mode code 01 (always on) adds no delay. The first `adc_sclk` fall comes CLK_DIV cycles after `adc_cs_n` falls, and the second rise comes 3*CLK_DIV cycles after that first fall.
- R7: In mode code 10 (auto power-down), at least WAKE_CYC cycles pass between the first falling and the second rising `adc_sclk` edge of every frame.
- R8: In mode code 11 (power-down while deselected) with `wake_dummy` low, at least WAKE_CYC cycles pass between the `adc_cs_n` fall and the first `adc_sclk` fall. The frame sends mode bits 11.
- R9: In mode code 11 with `wake_dummy` high, one request makes two frames. The first sends mode bits 01 with R6 timing and its data is dropped. The second sends mode bits 11 with R6 timing and gives the single `result_valid`.
- R10: Mode code 00 is sent as 01 and timed as in R6.
- R11: For mode codes other than 11, `wake_dummy` has no effect and each request makes exactly one frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Conversion request, accepted when idle |
| pm_sel | input | 2 | Target power-mode code |
| cfg | input | CTRL_BITS-2 | Configuration field sent in the control word |
| wake_dummy | input | 1 | Use a throwaway wake-up frame in mode 11 |
| adc_dout | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip select |
| adc_sclk | output | 1 | Serial clock, idles high |
| adc_din | output | 1 | Serial control data to the converter |
| result | output | FRAME_BITS | Last valid conversion word |
| result_valid | output | 1 | One-cycle strobe for `result` |
| busy | output | 1 | A request is in progress |

## Verification
The assertions check on every cycle that idle lines sit high when no request is active and that the serial clock moves only inside a frame. They also check that each frame closes after exactly sixteen rising clock edges, and that the valid strobe is one cycle long and coincides with the fall of busy. Only the bench's scenarios can show the other behaviours. These are the mode-dependent delays, the control word contents and bit order, the pairing and data discard of the wake-up frames, and the result bit order. The bench sweeps every mode code against both wake-up settings and several configuration patterns, and issues a stray request in each run to show it is ignored.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } seq_state_e;

    localparam logic [1:0] PM_RSVD = 2'b00;
    localparam logic [1:0] PM_ON   = 2'b01;
    localparam logic [1:0] PM_AUTO = 2'b10;
    localparam logic [1:0] PM_CSDN = 2'b11;

    // Reserved code is mapped onto the always-on code.
    function automatic logic [1:0] pm_effective(input logic [1:0] pm);
        return (pm == PM_RSVD) ? PM_ON : pm;
    endfunction

endpackage

// File: rtl/adc_seq_timer.sv
module adc_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_seq_shift.sv
module adc_seq_shift #(
    parameter int CTRL_BITS  = 8,
    parameter int FRAME_BITS = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [CTRL_BITS-1:0]  load_word,
    input  logic                  tx_step,
    input  logic                  rx_step,
    input  logic                  rx_bit,
    output logic                  din,
    output logic [FRAME_BITS-1:0] rx_word
);

    typedef struct packed {
        logic [CTRL_BITS-1:0]  tx;
        logic                  din;
        logic [FRAME_BITS-1:0] rx;
    } shift_t;

    shift_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.tx  = load_word;
            s_d.din = 1'b0;
        end else if (tx_step) begin
            s_d.din = s_q.tx[CTRL_BITS-1];
            s_d.tx  = {s_q.tx[CTRL_BITS-2:0], 1'b0};
        end
        if (rx_step) begin
            s_d.rx = {s_q.rx[FRAME_BITS-2:0], rx_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign din     = s_q.din;
    assign rx_word = s_q.rx;

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int FRAME_BITS = 16,
    parameter int CTRL_BITS  = 8,
    parameter int CLK_DIV    = 4,
    parameter int WAKE_CYC   = 1250,
    parameter int CW         = 11,
    localparam int CFG_W     = CTRL_BITS - 2,
    localparam int BW        = $clog2(FRAME_BITS)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [1:0]            pm_sel,
    input  logic [CFG_W-1:0]      cfg,
    input  logic                  wake_dummy,
    input  logic                  expired,
    input  logic [FRAME_BITS-1:0] rx_word,
    output logic                  tmr_load,
    output logic [CW-1:0]         tmr_val,
    output logic                  ld_ctrl,
    output logic [CTRL_BITS-1:0]  ctrl_word,
    output logic                  tx_step,
    output logic                  rx_step,
    output logic                  cs_n,
    output logic                  sclk,
    output logic                  busy,
    output logic                  valid,
    output logic [FRAME_BITS-1:0] result
);

    localparam logic [CW-1:0] T_HALF = CW'(CLK_DIV - 1);
    localparam logic [CW-1:0] T_WAKE = CW'(WAKE_CYC - 1);
    localparam logic [CW-1:0] T_GAP  = CW'(2 * CLK_DIV - 1);
    localparam logic [BW-1:0] LAST   = BW'(FRAME_BITS - 1);

    typedef struct packed {
        seq_state_e            st;
        logic [BW-1:0]         bit_idx;
        logic                  cs_n;
        logic                  sclk;
        logic                  busy;
        logic                  valid;
        logic [1:0]            pm;
        logic [CFG_W-1:0]      cfg;
        logic                  wd;
        logic                  dummy;
        logic [FRAME_BITS-1:0] result;
    } fsm_t;

    fsm_t q, n;
    logic launch;

    always_comb begin
        n         = q;
        n.valid   = 1'b0;
        launch    = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = T_HALF;
        tx_step   = 1'b0;
        rx_step   = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start) begin
                    n.busy  = 1'b1;
                    n.pm    = pm_effective(pm_sel);
                    n.cfg   = cfg;
                    n.wd    = (pm_sel == PM_CSDN) && wake_dummy;
                    n.dummy = n.wd;
                    launch  = 1'b1;
                end
            end
            ST_LEAD: begin
                if (expired) begin
                    n.st     = ST_LOW;
                    n.sclk   = 1'b0;
                    tx_step  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = T_HALF;
                end
            end
            ST_LOW: begin
                if (expired) begin
                    n.st     = ST_HIGH;
                    n.sclk   = 1'b1;
                    rx_step  = 1'b1;
                    tmr_load = 1'b1;
                    // auto power-down: stretch the first high phase
                    tmr_val  = (q.bit_idx == '0 && q.pm == PM_AUTO) ? T_WAKE : T_HALF;
                end
            end
            ST_HIGH: begin
                if (expired) begin
                    tmr_load = 1'b1;
                    if (q.bit_idx == LAST) begin
                        n.st    = ST_GAP;
                        n.cs_n  = 1'b1;
                        tmr_val = T_GAP;
                    end else begin
                        n.bit_idx = q.bit_idx + 1'b1;
                        n.st      = ST_LOW;
                        n.sclk    = 1'b0;
                        tx_step   = 1'b1;
                        tmr_val   = T_HALF;
                    end
                end
            end
            ST_GAP: begin
                if (expired) begin
                    if (q.dummy) begin
                        n.dummy = 1'b0;
                        launch  = 1'b1;
                    end else begin
                        n.st     = ST_IDLE;
                        n.busy   = 1'b0;
                        n.valid  = 1'b1;
                        n.result = rx_word;
                    end
                end
            end
            default: n.st = ST_IDLE;
        endcase

        ld_ctrl   = launch;
        ctrl_word = {(n.dummy ? PM_ON : n.pm), n.cfg};
        if (launch) begin
            n.st      = ST_LEAD;
            n.cs_n    = 1'b0;
            n.bit_idx = '0;
            tmr_load  = 1'b1;
            // deselect power-down without a wake-up pair waits before clocking
            tmr_val   = (n.pm == PM_CSDN && !n.wd) ? T_WAKE : T_HALF;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q        <= '0;
            q.st     <= ST_IDLE;
            q.cs_n   <= 1'b1;
            q.sclk   <= 1'b1;
        end else begin
            q <= n;
        end
    end

    assign cs_n   = q.cs_n;
    assign sclk   = q.sclk;
    assign busy   = q.busy;
    assign valid  = q.valid;
    assign result = q.result;

    // Checker-only counter of rising serial clock edges inside a frame.
    logic [BW:0] rise_cnt_q;
    always_ff @(posedge clk) begin
        if (!rst_n || q.cs_n) begin
            rise_cnt_q <= '0;
        end else if (n.sclk && !q.sclk) begin
            rise_cnt_q <= rise_cnt_q + 1'b1;
        end
    end

    p_idle_lines_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !q.busy |-> (q.cs_n && q.sclk));

    p_sclk_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.sclk) |-> !q.cs_n);

    p_frame_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.cs_n) |-> (rise_cnt_q == (BW+1)'(FRAME_BITS)));

    p_valid_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        q.valid |=> !q.valid);

    p_busy_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.busy) |-> q.valid);

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq #(
    parameter int FRAME_BITS = 16,
    parameter int CTRL_BITS  = 8,
    parameter int CLK_DIV    = 4,
    parameter int WAKE_CYC   = 1250,
    localparam int CFG_W     = CTRL_BITS - 2,
    localparam int MAX_T     = (WAKE_CYC > 2 * CLK_DIV) ? WAKE_CYC : 2 * CLK_DIV,
    localparam int CW        = $clog2(MAX_T + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [1:0]            pm_sel,
    input  logic [CFG_W-1:0]      cfg,
    input  logic                  wake_dummy,
    input  logic                  adc_dout,
    output logic                  adc_cs_n,
    output logic                  adc_sclk,
    output logic                  adc_din,
    output logic [FRAME_BITS-1:0] result,
    output logic                  result_valid,
    output logic                  busy
);

    logic                  tmr_load;
    logic [CW-1:0]         tmr_val;
    logic                  tmr_expired;
    logic                  ld_ctrl;
    logic [CTRL_BITS-1:0]  ctrl_word;
    logic                  tx_step;
    logic                  rx_step;
    logic [FRAME_BITS-1:0] rx_word;

    adc_seq_timer #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    adc_seq_shift #(
        .CTRL_BITS  (CTRL_BITS),
        .FRAME_BITS (FRAME_BITS)
    ) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ld_ctrl),
        .load_word (ctrl_word),
        .tx_step   (tx_step),
        .rx_step   (rx_step),
        .rx_bit    (adc_dout),
        .din       (adc_din),
        .rx_word   (rx_word)
    );

    adc_seq_fsm #(
        .FRAME_BITS (FRAME_BITS),
        .CTRL_BITS  (CTRL_BITS),
        .CLK_DIV    (CLK_DIV),
        .WAKE_CYC   (WAKE_CYC),
        .CW         (CW)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .pm_sel     (pm_sel),
        .cfg        (cfg),
        .wake_dummy (wake_dummy),
        .expired    (tmr_expired),
        .rx_word    (rx_word),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .ld_ctrl    (ld_ctrl),
        .ctrl_word  (ctrl_word),
        .tx_step    (tx_step),
        .rx_step    (rx_step),
        .cs_n       (adc_cs_n),
        .sclk       (adc_sclk),
        .busy       (busy),
        .valid      (result_valid),
        .result     (result)
    );

endmodule

// File: tb/tb_adc_conv_seq.sv
module tb_adc_conv_seq;

    localparam int DIV  = 2;
    localparam int WAKE = 20;
    localparam int FB   = 16;
    localparam int CB   = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  pm_sel = 2'b00;
    logic [5:0]  cfg = 6'h00;
    logic        wake_dummy = 1'b0;
    logic        adc_dout = 1'b0;
    logic        adc_cs_n, adc_sclk, adc_din, result_valid, busy;
    logic [15:0] result;

    always #2 clk = ~clk;

    adc_conv_seq #(
        .FRAME_BITS (FB),
        .CTRL_BITS  (CB),
        .CLK_DIV    (DIV),
        .WAKE_CYC   (WAKE)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .pm_sel       (pm_sel),
        .cfg          (cfg),
        .wake_dummy   (wake_dummy),
        .adc_dout     (adc_dout),
        .adc_cs_n     (adc_cs_n),
        .adc_sclk     (adc_sclk),
        .adc_din      (adc_din),
        .result       (result),
        .result_valid (result_valid),
        .busy         (busy)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input int k);
        return 16'(32'h9E37 * (k + 5)) ^ 16'h5A5A;
    endfunction

    // Converter model and line monitor, evaluated between clock edges.
    int          frames = 0, gfr = 0, falls = 0, rises = 0;
    int          t_csfall = 0, t_fall1 = 0, t_csrise = -1000;
    int          mon_bad = 0, vcount = 0;
    int          lead_rec [2];
    int          span_rec [2];
    logic [7:0]  ctrl_rec [2];
    logic [7:0]  din_sh = 8'h00;
    logic [15:0] curw = 16'h0000;
    logic [15:0] vres = 16'h0000;
    bit          prev_cs = 1'b1, prev_sclk = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !adc_cs_n) begin
                if (cyc - t_csrise < 2 * DIV) mon_bad++;
                curw = word_of(gfr);
                gfr++;
                falls = 0;
                rises = 0;
                din_sh = 8'h00;
                t_csfall = cyc;
            end
            if (!adc_cs_n && prev_sclk && !adc_sclk) begin
                if (falls < FB) adc_dout = curw[FB-1-falls];
                if (falls == 0) t_fall1 = cyc;
                falls++;
            end
            if (!adc_cs_n && !prev_sclk && adc_sclk) begin
                if (rises < CB) din_sh = {din_sh[6:0], adc_din};
                rises++;
                if (rises == 2 && frames < 2) begin
                    lead_rec[frames] = t_fall1 - t_csfall;
                    span_rec[frames] = cyc - t_fall1;
                end
            end
            if (prev_sclk != adc_sclk && adc_cs_n) mon_bad++;
            if (!prev_cs && adc_cs_n) begin
                if (rises != FB) mon_bad++;
                if (frames < 2) ctrl_rec[frames] = din_sh;
                frames++;
                t_csrise = cyc;
            end
            if (!adc_cs_n && !busy) mon_bad++;
            if (result_valid) begin
                vcount++;
                vres = result;
            end
        end
        prev_cs = adc_cs_n;
        prev_sclk = adc_sclk;
    end

    task automatic run(input int pm, input int wd, input logic [5:0] c);
        int         nfr, base, w;
        logic [1:0] pm0;
        @(negedge clk);
        frames = 0;
        vcount = 0;
        mon_bad = 0;
        base = gfr;
        pm_sel = 2'(pm);
        wake_dummy = wd[0];
        cfg = c;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R5 busy after accepted start", int'(busy), 1);
        // stray request with different settings while busy
        pm_sel = 2'b10;
        cfg = ~c;
        wake_dummy = ~wd[0];
        repeat (5) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        w = 0;
        while (vcount == 0 && w < 3000) begin
            @(negedge clk);
            w++;
        end
        repeat (2 * DIV + 4) @(negedge clk);

        nfr = (pm == 3 && wd == 1) ? 2 : 1;
        if (pm == 3) chk(frames == nfr, "R9 frame count", frames, nfr);
        else         chk(frames == nfr, "R11 frame count", frames, nfr);
        chk(vcount == 1, "R5 single valid strobe", vcount, 1);
        chk(mon_bad == 0, "R2 frame shape and gaps", mon_bad, 0);

        pm0 = (nfr == 2) ? 2'b01 : ((pm == 0) ? 2'b01 : 2'(pm));
        if (pm == 0) chk(ctrl_rec[0] == {pm0, c}, "R10 control word", int'(ctrl_rec[0]), int'({pm0, c}));
        else         chk(ctrl_rec[0] == {pm0, c}, "R3 control word", int'(ctrl_rec[0]), int'({pm0, c}));
        chk(vres == word_of(base + nfr - 1), "R4 result word", int'(vres), int'(word_of(base + nfr - 1)));

        if (pm == 3 && wd == 0) chk(lead_rec[0] >= WAKE, "R8 select-to-clock delay", lead_rec[0], WAKE);
        else                    chk(lead_rec[0] == DIV, "R6 lead time", lead_rec[0], DIV);
        if (pm == 2) chk(span_rec[0] >= WAKE, "R7 in-frame delay", span_rec[0], WAKE);
        else         chk(span_rec[0] == 3 * DIV, "R6 first-fall to second-rise", span_rec[0], 3 * DIV);

        if (nfr == 2) begin
            chk(ctrl_rec[1] == {2'b11, c}, "R9 second control word", int'(ctrl_rec[1]), int'({2'b11, c}));
            chk(lead_rec[1] == DIV, "R9 second lead time", lead_rec[1], DIV);
            chk(span_rec[1] == 3 * DIV, "R9 second frame span", span_rec[1], 3 * DIV);
        end
        chk(adc_cs_n && adc_sclk && !busy, "R1 idle lines after request",
            int'({adc_cs_n, adc_sclk, busy}), 6);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(adc_cs_n && adc_sclk && !busy && !result_valid && !adc_din, "R1 during reset",
            int'({adc_cs_n, adc_sclk, busy, result_valid, adc_din}), 24);
        rst_n = 1'b1;
        @(negedge clk);
        chk(adc_cs_n && adc_sclk && !busy && !result_valid && !adc_din, "R1 after reset",
            int'({adc_cs_n, adc_sclk, busy, result_valid, adc_din}), 24);
        for (int pm = 0; pm < 4; pm++) begin
            for (int wd = 0; wd < 2; wd++) begin
                for (int ci = 0; ci < 4; ci++) begin
                    run(pm, wd, 6'(ci * 21));
                end
            end
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule